// File: doc/BRIEF.md
# UART Register Shell

This block is the software-visible face of a simple UART. It sits on a plain word-addressed bus with an address, a write strobe with write data, and a read strobe with registered read data. Behind it are a serial receiver and a serializer, and both stay outside the block. The receiver offers one byte at a time through a valid/ready handshake. The shell holds that byte in a one-byte data register until software reads it. Writing the same data address sends the low byte of the written word to the serializer as a single-cycle strobe.

The shell tracks the receive-empty and transmit-empty flags. It exposes two interrupt status bits and drives a receive interrupt line and a transmit interrupt line. A read of the data register has a side effect: it takes the byte and frees the holding slot. The transmit interrupt follows the transmit-interrupt-enable bit directly, each time the control register is written. Baud timing, bit framing, FIFOs, modem and DMA controls are not part of the block. Their offsets read as zero and ignore writes.

Top module: `uart_reg_shell`

## Requirements
- R1: After reset the flag register (offset 0x18) reads 0x90, and the data register (0x00), the identification register (0x1C) and the control register (0x14) read 0. irq_rx, irq_tx and tx_strobe are low and rx_ready is high.
- R2: rx_ready is high exactly when no byte is held. A cycle with rx_valid and rx_ready both high captures rx_data, including the value 0x00. From the next cycle irq_rx is high, rx_ready is low, flag bit 4 (receive empty) is 0 and identification bit 1 (receive status) is 1.
- R3: While a byte is held, rx_ready stays low. Further rx_valid cycles leave the held byte and irq_rx unchanged.
- R4: A read of offset 0x00 returns the held byte in bits 7:0, with zeros above. Afterwards the data register reads 0, flag bit 4 is 1, identification bit 1 is 0, irq_rx is low and rx_ready is high.
- R5: A write to offset 0x00 raises tx_strobe for exactly one cycle, the cycle after the write, with tx_data equal to bits 7:0 of the written word. The held receive byte is not affected.
- R6: A write to offset 0x14 stores bits 7:0, which read back at 0x14. Bit 5 of the written value sets both irq_tx and identification bit 2 (transmit status) when it is 1, and clears both when it is 0. Only a control write changes irq_tx.
- R7: bus_rdata carries the addressed value in the cycle after bus_rd is high, and is 0 in the cycle after bus_rd is low.
- R8: Every other offset reads as 0, including 0x04 and the addresses that are not word aligned. Writes to those offsets, to the flag register or to the identification register change no readable state, no interrupt line and no strobe.
- R9: Flag bit 7 (transmit empty) always reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | DATA_W | Read data, one cycle after bus_rd |
| rx_valid | input | 1 | Receiver offers a byte |
| rx_data | input | BYTE_W | Offered byte |
| rx_ready | output | 1 | Shell can take a byte |
| tx_strobe | output | 1 | One-cycle pulse carrying a byte to transmit |
| tx_data | output | BYTE_W | Byte to transmit |
| irq_rx | output | 1 | Receive interrupt |
| irq_tx | output | 1 | Transmit interrupt |

## Verification
The bench builds the shell with its defaults: a 5-bit address, 32-bit data, a one-byte data register and an 8-bit control register. The 5-bit address makes the whole 32-byte window small enough to sweep every address, aligned or not, for reads and ignored writes. The 8-bit control width lets a full-word write show that the upper bits are dropped. The 8-bit byte width brings the zero-valued received byte into reach, so the test can show that the slot's occupancy does not depend on the byte's value.

// File: rtl/uart_shell_pkg.sv
package uart_shell_pkg;

    // byte offsets inside the register window
    localparam int OFF_DATA   = 'h00;
    localparam int OFF_RXSTAT = 'h04;
    localparam int OFF_CTRL   = 'h14;
    localparam int OFF_FLAGS  = 'h18;
    localparam int OFF_IDENT  = 'h1C;

    // bit positions
    localparam int FLAG_TXE  = 7;
    localparam int FLAG_RXE  = 4;
    localparam int IDENT_RX  = 1;
    localparam int IDENT_TX  = 2;
    localparam int CTRL_TXIE = 5;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_DATA,
        SEL_CTRL,
        SEL_FLAGS,
        SEL_IDENT
    } reg_sel_e;

endpackage

// File: rtl/uart_rx_hold.sv
module uart_rx_hold #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_data,
    output logic              rx_ready,
    input  logic              take_byte,
    output logic [BYTE_W-1:0] hold_byte,
    output logic              hold_full
);

    typedef struct packed {
        logic [BYTE_W-1:0] val;
        logic              full;
    } hold_t;

    hold_t s_d, s_q;

    assign rx_ready  = !s_q.full;
    assign hold_byte = s_q.val;
    assign hold_full = s_q.full;

    always_comb begin
        s_d = s_q;
        if (take_byte) begin
            s_d.val  = '0;
            s_d.full = 1'b0;
        end
        // a new byte can only arrive while the slot is free, so it never
        // collides with a take of a real byte
        if (rx_valid && rx_ready) begin
            s_d.val  = rx_data;
            s_d.full = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/uart_ctl_tx.sv
module uart_ctl_tx #(
    parameter int DATA_W = 32,
    parameter int CTRL_W = 8,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl,
    input  logic              wr_txd,
    input  logic [DATA_W-1:0] wdata,
    output logic [CTRL_W-1:0] ctrl_val,
    output logic              tx_int,
    output logic              tx_strobe,
    output logic [BYTE_W-1:0] tx_data
);

    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
        logic              txi;
        logic              strobe;
        logic [BYTE_W-1:0] txd;
    } ctl_t;

    ctl_t s_d, s_q;

    assign ctrl_val  = s_q.ctrl;
    assign tx_int    = s_q.txi;
    assign tx_strobe = s_q.strobe;
    assign tx_data   = s_q.txd;

    always_comb begin
        s_d        = s_q;
        s_d.strobe = 1'b0;
        if (wr_ctrl) begin
            s_d.ctrl = wdata[CTRL_W-1:0];
            s_d.txi  = wdata[uart_shell_pkg::CTRL_TXIE];
        end
        if (wr_txd) begin
            s_d.strobe = 1'b1;
            s_d.txd    = wdata[BYTE_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/uart_rd_path.sv
module uart_rd_path #(
    parameter int DATA_W = 32,
    parameter int CTRL_W = 8,
    parameter int BYTE_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     rd_en,
    input  uart_shell_pkg::reg_sel_e sel,
    input  logic [BYTE_W-1:0]        hold_byte,
    input  logic                     hold_full,
    input  logic [CTRL_W-1:0]        ctrl_val,
    input  logic                     tx_int,
    output logic [DATA_W-1:0]        rdata
);
    import uart_shell_pkg::*;

    typedef struct packed {
        logic [DATA_W-1:0] word;
    } rd_t;

    rd_t s_d, s_q;
    logic [DATA_W-1:0] mux_val;

    assign rdata = s_q.word;

    always_comb begin
        mux_val = '0;
        case (sel)
            SEL_DATA:  mux_val[BYTE_W-1:0] = hold_byte;
            SEL_CTRL:  mux_val[CTRL_W-1:0] = ctrl_val;
            SEL_FLAGS: begin
                mux_val[FLAG_TXE] = 1'b1;
                mux_val[FLAG_RXE] = !hold_full;
            end
            SEL_IDENT: begin
                mux_val[IDENT_RX] = hold_full;
                mux_val[IDENT_TX] = tx_int;
            end
            default:   mux_val = '0;
        endcase
        s_d.word = rd_en ? mux_val : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/uart_reg_shell.sv
module uart_reg_shell #(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8,
    parameter int CTRL_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_data,
    output logic              rx_ready,
    output logic              tx_strobe,
    output logic [BYTE_W-1:0] tx_data,
    output logic              irq_rx,
    output logic              irq_tx
);
    import uart_shell_pkg::*;

    localparam logic [ADDR_W-1:0] A_DATA  = ADDR_W'(OFF_DATA);
    localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFF_CTRL);
    localparam logic [ADDR_W-1:0] A_FLAGS = ADDR_W'(OFF_FLAGS);
    localparam logic [ADDR_W-1:0] A_IDENT = ADDR_W'(OFF_IDENT);

    reg_sel_e          sel;
    logic              take_byte;
    logic              wr_ctrl;
    logic              wr_txd;
    logic [BYTE_W-1:0] hold_byte;
    logic              hold_full;
    logic [CTRL_W-1:0] ctrl_val;
    logic              tx_int;

    always_comb begin
        case (bus_addr)
            A_DATA:  sel = SEL_DATA;
            A_CTRL:  sel = SEL_CTRL;
            A_FLAGS: sel = SEL_FLAGS;
            A_IDENT: sel = SEL_IDENT;
            default: sel = SEL_NONE;
        endcase
    end

    assign take_byte = bus_rd && (sel == SEL_DATA);
    assign wr_ctrl   = bus_wr && (sel == SEL_CTRL);
    assign wr_txd    = bus_wr && (sel == SEL_DATA);

    uart_rx_hold #(.BYTE_W(BYTE_W)) i_rx_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_valid  (rx_valid),
        .rx_data   (rx_data),
        .rx_ready  (rx_ready),
        .take_byte (take_byte),
        .hold_byte (hold_byte),
        .hold_full (hold_full)
    );

    uart_ctl_tx #(.DATA_W(DATA_W), .CTRL_W(CTRL_W), .BYTE_W(BYTE_W)) i_ctl_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_ctrl   (wr_ctrl),
        .wr_txd    (wr_txd),
        .wdata     (bus_wdata),
        .ctrl_val  (ctrl_val),
        .tx_int    (tx_int),
        .tx_strobe (tx_strobe),
        .tx_data   (tx_data)
    );

    uart_rd_path #(.DATA_W(DATA_W), .CTRL_W(CTRL_W), .BYTE_W(BYTE_W)) i_rd_path (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en     (bus_rd),
        .sel       (sel),
        .hold_byte (hold_byte),
        .hold_full (hold_full),
        .ctrl_val  (ctrl_val),
        .tx_int    (tx_int),
        .rdata     (bus_rdata)
    );

    assign irq_rx = hold_full;
    assign irq_tx = tx_int;

endmodule

// File: rtl/uart_reg_shell_chk.sv
module uart_reg_shell_chk #(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_rd,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              rx_valid,
    input logic              rx_ready,
    input logic              tx_strobe,
    input logic [BYTE_W-1:0] tx_data,
    input logic              irq_rx,
    input logic              irq_tx
);
    localparam logic [ADDR_W-1:0] CA_DATA = ADDR_W'(uart_shell_pkg::OFF_DATA);
    localparam logic [ADDR_W-1:0] CA_CTRL = ADDR_W'(uart_shell_pkg::OFF_CTRL);

    AST_RX_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_ready) |=> (irq_rx && !rx_ready)); // R2

    AST_RX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_rx && !(bus_rd && bus_addr == CA_DATA)) |=> irq_rx); // R3

    AST_RX_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == CA_DATA) |=> (!irq_rx && rx_ready)); // R4

    AST_TX_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == CA_DATA) |=>
        (tx_strobe && tx_data == $past(bus_wdata[BYTE_W-1:0]))); // R5

    AST_TX_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_strobe |-> $past(bus_wr && bus_addr == CA_DATA)); // R5

    AST_TXI_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == CA_CTRL) |=>
        (irq_tx == $past(bus_wdata[uart_shell_pkg::CTRL_TXIE]))); // R6

    AST_TXI_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == CA_CTRL) |=> $stable(irq_tx)); // R6

    AST_RD_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> (bus_rdata == '0)); // R7

endmodule

bind uart_reg_shell uart_reg_shell_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BYTE_W(BYTE_W)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .rx_valid  (rx_valid),
    .rx_ready  (rx_ready),
    .tx_strobe (tx_strobe),
    .tx_data   (tx_data),
    .irq_rx    (irq_rx),
    .irq_tx    (irq_tx)
);

// File: tb/test_uart_reg_shell.sv
module test_uart_reg_shell;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_ready;
    logic        tx_strobe;
    logic [7:0]  tx_data;
    logic        irq_rx;
    logic        irq_tx;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    uart_reg_shell i_uart_reg_shell (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
        .tx_strobe(tx_strobe), .tx_data(tx_data), .irq_rx(irq_rx), .irq_tx(irq_tx)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rx_push(input logic [7:0] b, output logic rdy_seen);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = b;
        rdy_seen = rx_ready;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        bus_read(5'h18, d); chk("R1 flags", d, 32'h90);
        chk("R9 txe", {31'b0, d[7]}, 32'h1);
        bus_read(5'h00, d); chk("R1 data", d, 32'h0);
        bus_read(5'h1C, d); chk("R1 ident", d, 32'h0);
        bus_read(5'h14, d); chk("R1 ctrl", d, 32'h0);
        chk("R1 irqs/strobe", {29'b0, irq_rx, irq_tx, tx_strobe}, 32'h0);
        chk("R1 rx_ready", {31'b0, rx_ready}, 32'h1);
    endtask

    task automatic t_rx_accept_and_hold();
        logic rdy;
        logic [31:0] d;
        rx_push(8'hA5, rdy);
        chk("R2 ready before", {31'b0, rdy}, 32'h1);
        chk("R2 irq_rx", {31'b0, irq_rx}, 32'h1);
        chk("R2 ready after", {31'b0, rx_ready}, 32'h0);
        bus_read(5'h18, d); chk("R2 flags", d, 32'h80);
        bus_read(5'h1C, d); chk("R2 ident", d, 32'h2);
        rx_push(8'h3C, rdy);
        chk("R3 ready held", {31'b0, rdy}, 32'h0);
        chk("R3 irq held", {31'b0, irq_rx}, 32'h1);
        bus_read(5'h00, d); chk("R4 byte", d, 32'hA5);
        chk("R4 irq_rx low", {31'b0, irq_rx}, 32'h0);
        chk("R4 ready back", {31'b0, rx_ready}, 32'h1);
        bus_read(5'h00, d); chk("R4 data zero", d, 32'h0);
        bus_read(5'h18, d); chk("R4 flags", d, 32'h90);
        bus_read(5'h1C, d); chk("R4 ident", d, 32'h0);
    endtask

    task automatic t_rx_zero_byte();
        logic rdy;
        logic [31:0] d;
        rx_push(8'h00, rdy);
        chk("R2 zero accepted", {31'b0, rdy}, 32'h1);
        chk("R2 zero blocks", {31'b0, rx_ready}, 32'h0);
        bus_read(5'h18, d); chk("R2 zero flags", d, 32'h80);
        bus_read(5'h00, d); chk("R4 zero byte", d, 32'h0);
        bus_read(5'h18, d); chk("R4 zero flags", d, 32'h90);
    endtask

    task automatic t_tx();
        logic rdy;
        logic [31:0] d;
        rx_push(8'h77, rdy);
        bus_write(5'h00, 32'h1234_56C3);
        chk("R5 strobe", {31'b0, tx_strobe}, 32'h1);
        chk("R5 tx_data", {24'b0, tx_data}, 32'hC3);
        @(negedge clk);
        chk("R5 one cycle", {31'b0, tx_strobe}, 32'h0);
        bus_read(5'h00, d); chk("R5 rx byte kept", d, 32'h77);
    endtask

    task automatic t_ctrl();
        logic rdy;
        logic [31:0] d;
        bus_write(5'h14, 32'hFFFF_FF20);
        chk("R6 irq_tx set", {31'b0, irq_tx}, 32'h1);
        bus_read(5'h14, d); chk("R6 ctrl readback", d, 32'h20);
        bus_read(5'h1C, d); chk("R6 ident tx", d, 32'h4);
        rx_push(8'h5A, rdy);
        bus_read(5'h1C, d); chk("R6 ident both", d, 32'h6);
        chk("R6 irq_tx kept", {31'b0, irq_tx}, 32'h1);
        bus_read(5'h00, d);
        bus_write(5'h14, 32'h0000_001F);
        chk("R6 irq_tx clear", {31'b0, irq_tx}, 32'h0);
        bus_read(5'h14, d); chk("R6 ctrl second", d, 32'h1F);
        bus_read(5'h1C, d); chk("R6 ident clear", d, 32'h0);
    endtask

    task automatic t_latency();
        logic [31:0] d;
        bus_read(5'h14, d); chk("R7 read value", d, 32'h1F);
        @(negedge clk);
        chk("R7 idle zero", bus_rdata, 32'h0);
    endtask

    task automatic t_unimpl();
        logic [31:0] d;
        int strobes = 0;
        for (int a = 0; a < 32; a++) begin
            if (a != 'h00 && a != 'h14) begin
                bus_write(5'(a), 32'hFFFF_FFFF);
                if (tx_strobe) strobes++;
            end
        end
        chk("R8 no strobe", strobes, 32'h0);
        chk("R8 irqs", {30'b0, irq_rx, irq_tx}, 32'h0);
        for (int a = 0; a < 32; a++) begin
            bus_read(5'(a), d);
            case (a)
                'h14:    chk("R8 ctrl kept", d, 32'h1F);
                'h18:    chk("R8 flags kept", d, 32'h90);
                'h00, 'h1C: chk("R8 zero reg", d, 32'h0);
                default: chk("R8 unimpl zero", d, 32'h0);
            endcase
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_rx_accept_and_hold();
        t_rx_zero_byte();
        t_tx();
        t_ctrl();
        t_latency();
        t_unimpl();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule